// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block lets a host on a two-wire SMBus/I2C bus read and write a small bank of 8-bit configuration registers, for example per-output clock enable bits. The bank's contents are always visible on a parallel output bus, and every register starts from a parameterised power-up value. The host reaches the block at 7-bit address 69h. That is address byte D2h for writes and D3h for reads.

After the address, the host sends a command byte. If bit 7 of the command is set, the access is a single indexed access, and bits 6:0 of the command hold the register offset. If bit 7 is clear, the access is a block access that starts at offset zero and walks upward one register per byte.

A block write carries a byte count, which the block consumes, before the data bytes. A block read is turned around with a repeated start and the read address, and the block first returns a count equal to the bank size. The host may end any transfer after a complete byte. SCL and SDA are oversampled on the system clock, and the block drives SDA low only through an open-drain enable.

Top module: `smb_cfg_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal DEV_ADDR (default 69h). Any other address is left unacknowledged, and the rest of that frame is ignored.
- R2: A command byte with bit 7 = 1 selects single access at the offset given by bits 6:0. A command byte with bit 7 = 0 selects block access starting at offset 0.
- R3: A single write stores the one data byte that follows the command, and acknowledges it. Further data bytes in the same frame are not acknowledged and are not stored.
- R4: A block write acknowledges the count byte and every data byte. It stores the data bytes at offsets 0, 1, 2 and upward, in order.
- R5: A block read, made with a repeated start and read address D3h, first returns the value NREG. It then returns the registers from offset 0 upward.
- R6: A single read returns the addressed register, most significant bit first. If the host acknowledges, the read continues with the next offset.
- R7: A block transfer ended by the host after any complete byte leaves every register that was not reached unchanged.
- R8: Offsets at or above NREG read back as 00h. A write to such an offset is acknowledged but has no effect.
- R9: After a not-acknowledge from the host, SDA is released. A stop condition returns the block to idle, ready for the next frame.
- R10: Reset loads every register with its RESET_VAL byte, with register i taken from bits 8i+7:8i.
- R11: The SDA drive enable changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Drive SDA low when 1 (open drain) |
| cfg_q | output | NREG*8 | Register bank contents, register i at bits 8i+7:8i |

## Verification
The bench builds the block with NREG = 8, DEV_ADDR = 69h and a distinct non-uniform RESET_VAL. With these values, an error in the reset value or in how register bytes are placed on the output bus changes a visible byte. Eight registers are few enough that single reads can step past the end of the bank, which brings the zero read-back and the ignored write at offset 0Ah within reach. Block transfers are run both to completion and cut short after a few bytes. This exposes the count byte, the ascending pointer order and the registers that must stay untouched.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_WDATA,
    ST_TX,
    ST_SKIP
  } smb_state_e;

  // Upper seven bits of the address byte select the device.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  function automatic logic cmd_is_block(input logic [7:0] c);
    return ~c[7];
  endfunction

  // Block access always starts at offset zero.
  function automatic logic [6:0] cmd_offset(input logic [7:0] c);
    return c[7] ? c[6:0] : 7'd0;
  endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_p;
  logic              sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int                 NREG      = 8,
  parameter logic [NREG*8-1:0]  RESET_VAL = {NREG{8'hFF}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [6:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [6:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] cfg_q
);

  logic [7:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[i] <= RESET_VAL[i*8 +: 8];
      else if (wr_en && wr_addr == 7'(i))
        regs[i] <= wr_data;
    end
    assign cfg_q[i*8 +: 8] = regs[i];
  end

  // Offsets past the bank match no register and read as zero.
  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == 7'(i)) rd_data = regs[i];
  end

endmodule

// File: rtl/smb_engine.sv
module smb_engine
  import smb_pkg::*;
#(
  parameter int         NREG     = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [6:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [6:0] rd_addr,
  output smb_state_e state
);

  localparam logic [7:0] CNT_BYTE = 8'(NREG);

  smb_state_e nxt;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [7:0] txsh;
  logic [6:0] ptr;
  logic       in_ack;
  logic       blk;
  logic       pend_cnt;
  logic       host_ack;
  logic [7:0] tx_next;

  assign rd_addr = ptr;
  assign tx_next = pend_cnt ? CNT_BYTE : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      nxt      <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txsh     <= '0;
      ptr      <= '0;
      in_ack   <= 1'b0;
      blk      <= 1'b0;
      pend_cnt <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_CMD, ST_CNT, ST_WDATA: begin
            if (!in_ack) begin
              if (scl_rise && bitcnt != 4'd8) begin
                shreg  <= {shreg[6:0], sda_s};
                bitcnt <= bitcnt + 4'd1;
              end else if (scl_fall && bitcnt == 4'd8) begin
                in_ack <= 1'b1;
                unique case (state)
                  ST_ADDR: begin
                    if (addr_hit(shreg, DEV_ADDR)) begin
                      sda_oe <= 1'b1;
                      if (shreg[0]) begin
                        nxt      <= ST_TX;
                        pend_cnt <= blk;
                      end else begin
                        nxt <= ST_CMD;
                      end
                    end else begin
                      nxt <= ST_SKIP;
                    end
                  end
                  ST_CMD: begin
                    sda_oe <= 1'b1;
                    ptr    <= cmd_offset(shreg);
                    blk    <= cmd_is_block(shreg);
                    nxt    <= cmd_is_block(shreg) ? ST_CNT : ST_WDATA;
                  end
                  ST_CNT: begin
                    sda_oe <= 1'b1;
                    nxt    <= ST_WDATA;
                  end
                  default: begin
                    sda_oe  <= 1'b1;
                    wr_en   <= 1'b1;
                    wr_addr <= ptr;
                    wr_data <= shreg;
                    ptr     <= ptr + 7'd1;
                    nxt     <= blk ? ST_WDATA : ST_SKIP;
                  end
                endcase
              end
            end else if (scl_fall) begin
              in_ack <= 1'b0;
              bitcnt <= '0;
              state  <= nxt;
              if (nxt == ST_TX) begin
                txsh     <= tx_next;
                sda_oe   <= ~tx_next[7];
                pend_cnt <= 1'b0;
                if (!pend_cnt) ptr <= ptr + 7'd1;
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (!in_ack) begin
              if (scl_rise) begin
                bitcnt <= bitcnt + 4'd1;
              end else if (scl_fall) begin
                if (bitcnt == 4'd8) begin
                  sda_oe <= 1'b0;
                  in_ack <= 1'b1;
                end else begin
                  txsh   <= {txsh[6:0], 1'b0};
                  sda_oe <= ~txsh[6];
                end
              end
            end else begin
              if (scl_rise) begin
                host_ack <= ~sda_s;
              end else if (scl_fall) begin
                in_ack <= 1'b0;
                bitcnt <= '0;
                if (host_ack) begin
                  txsh   <= tx_next;
                  sda_oe <= ~tx_next[7];
                  ptr    <= ptr + 7'd1;
                end else begin
                  state  <= ST_SKIP;
                  sda_oe <= 1'b0;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_pkg::*;
#(
  parameter int                NREG      = 8,
  parameter logic [6:0]        DEV_ADDR  = 7'h69,
  parameter logic [NREG*8-1:0] RESET_VAL = {NREG{8'hFF}},
  parameter int                SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_q
);

  // Internal events, named for the checker.
  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_det;
  logic       stop_det;
  logic       wr_en;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic [6:0] rd_addr;
  logic [7:0] rd_data;
  smb_state_e eng_state;

  smb_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_engine #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .state     (eng_state)
  );

  smb_regbank #(.NREG(NREG), .RESET_VAL(RESET_VAL)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .cfg_q   (cfg_q)
  );

endmodule

// File: rtl/smb_cfg_checker.sv
module smb_cfg_checker
  import smb_pkg::*;
#(
  parameter int NREG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              stop_det,
  input logic              start_det,
  input logic              sda_oe,
  input logic              wr_en,
  input logic [6:0]        wr_addr,
  input logic [NREG*8-1:0] cfg_q,
  input smb_state_e        eng_state
);

  a_r11_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  a_r9_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_state == ST_IDLE) |-> !sda_oe);

  a_r8_high_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= 7'(NREG)) |=> $stable(cfg_q));

  a_r3_store_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sda_oe);

endmodule

bind smb_cfg_slave smb_cfg_checker #(.NREG(NREG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .stop_det  (stop_det),
  .start_det (start_det),
  .sda_oe    (sda_oe),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .cfg_q     (cfg_q),
  .eng_state (eng_state)
);

// File: tb/sim_smb_cfg_slave.sv
`timescale 1ns/1ps
module sim_smb_cfg_slave;

  localparam int          NREG = 8;
  localparam logic [63:0] DEF  = 64'h0F1E_2D3C_4B5A_6978;
  localparam time         Q    = 32ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        host_sda = 1'b1;
  logic        dut_oe;
  logic        sda_line;
  logic [63:0] cfg_q;

  always #2 clk = ~clk;

  assign sda_line = host_sda & ~dut_oe;

  smb_cfg_slave #(.NREG(NREG), .DEV_ADDR(7'h69), .RESET_VAL(DEF)) u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl),
    .sda_i  (sda_line),
    .sda_oe (dut_oe),
    .cfg_q  (cfg_q)
  );

  typedef struct {
    string       req;
    logic [63:0] val;
  } item_t;

  item_t       exp_q[$];
  event        obs_ev;
  logic [63:0] obs_val;
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [63:0] mdl;

  // Scoreboard monitor
  initial begin
    forever begin
      @(obs_ev);
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL unexpected observation got %h expected none", obs_val);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        n_cmp++;
        if (obs_val !== it.val) begin
          n_bad++;
          $display("FAIL %s got %h expected %h", it.req, obs_val, it.val);
        end
      end
    end
  end

  task automatic expect_v(input string req, input logic [63:0] v);
    exp_q.push_back('{req, v});
  endtask

  task automatic observe(input logic [63:0] v);
    obs_val = v;
    ->obs_ev;
    #1;
  endtask

  task automatic send_bit(input logic b);
    host_sda = b; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
  endtask

  task automatic recv_bit(output logic b);
    host_sda = 1'b1; #Q; scl = 1'b1; #Q; b = sda_line; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_start;
    host_sda = 1'b1; #Q; scl = 1'b1; #Q; host_sda = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_stop;
    host_sda = 1'b0; #Q; scl = 1'b1; #Q; host_sda = 1'b1; #(2*Q);
  endtask

  // Ack bit: 0 = acknowledged, 1 = not acknowledged.
  task automatic wbyte(input logic [7:0] b, input logic ack_bit, input string req);
    logic a;
    expect_v(req, 64'(ack_bit));
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(a);
    observe(64'(a));
  endtask

  task automatic rbyte(input logic host_ack, input logic [7:0] exp, input string req);
    logic [7:0] v;
    logic       b;
    expect_v(req, 64'(exp));
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    observe(64'(v));
    send_bit(~host_ack);
  endtask

  task automatic check_cfg(input string req);
    expect_v(req, mdl);
    observe(cfg_q);
  endtask

  task automatic check_oe_low(input string req);
    expect_v(req, 64'd0);
    observe(64'(dut_oe));
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    mdl = DEF;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check_cfg("R10 reset defaults");
    check_oe_low("R9 idle no drive");

    // R2/R3: single write to offset 3, extra byte refused
    bus_start();
    wbyte(8'hD2, 1'b0, "R1 address ack");
    wbyte(8'h83, 1'b0, "R2 single command ack");
    wbyte(8'hA5, 1'b0, "R3 data ack");
    wbyte(8'h77, 1'b1, "R3 extra byte nack");
    bus_stop();
    mdl[3*8 +: 8] = 8'hA5;
    check_cfg("R3 single write stored once");

    // R6: single read offset 3
    bus_start();
    wbyte(8'hD2, 1'b0, "R1 address ack");
    wbyte(8'h83, 1'b0, "R2 command ack");
    bus_start();
    wbyte(8'hD3, 1'b0, "R1 read address ack");
    rbyte(1'b0, 8'hA5, "R6 single read value");
    check_oe_low("R9 release after nack");
    bus_stop();

    // R1: foreign address
    bus_start();
    wbyte(8'hA0, 1'b1, "R1 foreign address nack");
    wbyte(8'h80, 1'b1, "R1 frame ignored");
    bus_stop();
    check_cfg("R1 no effect");

    // R7: block write cut after three bytes
    bus_start();
    wbyte(8'hD2, 1'b0, "R1 address ack");
    wbyte(8'h00, 1'b0, "R2 block command ack");
    wbyte(8'h08, 1'b0, "R4 count ack");
    wbyte(8'h11, 1'b0, "R4 data ack");
    wbyte(8'h22, 1'b0, "R4 data ack");
    wbyte(8'h33, 1'b0, "R4 data ack");
    bus_stop();
    mdl[7:0] = 8'h11; mdl[15:8] = 8'h22; mdl[23:16] = 8'h33;
    check_cfg("R7 early stop leaves rest");

    // R4: full block write
    bus_start();
    wbyte(8'hD2, 1'b0, "R1 address ack");
    wbyte(8'h00, 1'b0, "R2 block command ack");
    wbyte(8'h08, 1'b0, "R4 count ack");
    for (int i = 0; i < NREG; i++) begin
      wbyte(8'hC0 + 8'(i), 1'b0, "R4 data ack");
      mdl[i*8 +: 8] = 8'hC0 + 8'(i);
    end
    bus_stop();
    check_cfg("R4 block write order");

    // R5: full block read
    bus_start();
    wbyte(8'hD2, 1'b0, "R1 address ack");
    wbyte(8'h00, 1'b0, "R2 block command ack");
    bus_start();
    wbyte(8'hD3, 1'b0, "R1 read address ack");
    rbyte(1'b1, 8'(NREG), "R5 count byte");
    for (int i = 0; i < NREG; i++)
      rbyte(i != NREG - 1, mdl[i*8 +: 8], "R5 block read data");
    check_oe_low("R9 release after nack");
    bus_stop();

    // R8: write past the bank is acked but ignored
    bus_start();
    wbyte(8'hD2, 1'b0, "R1 address ack");
    wbyte(8'h8A, 1'b0, "R2 command ack");
    wbyte(8'h5E, 1'b0, "R8 high offset write ack");
    bus_stop();
    check_cfg("R8 high write ignored");

    // R8/R6: sequential single read walks off the end
    bus_start();
    wbyte(8'hD2, 1'b0, "R1 address ack");
    wbyte(8'h86, 1'b0, "R2 command ack");
    bus_start();
    wbyte(8'hD3, 1'b0, "R1 read address ack");
    rbyte(1'b1, mdl[6*8 +: 8], "R6 offset 6");
    rbyte(1'b1, mdl[7*8 +: 8], "R6 continue offset 7");
    rbyte(1'b0, 8'h00, "R8 past bank reads zero");
    bus_stop();

    // R7: block read cut after first data byte, then R9 recovery
    bus_start();
    wbyte(8'hD2, 1'b0, "R1 address ack");
    wbyte(8'h00, 1'b0, "R2 block command ack");
    bus_start();
    wbyte(8'hD3, 1'b0, "R1 read address ack");
    rbyte(1'b1, 8'(NREG), "R5 count byte");
    rbyte(1'b0, mdl[7:0], "R7 early block read");
    bus_stop();
    bus_start();
    wbyte(8'hD2, 1'b0, "R9 ready after stop");
    wbyte(8'h81, 1'b0, "R2 command ack");
    bus_start();
    wbyte(8'hD3, 1'b0, "R1 read address ack");
    rbyte(1'b0, mdl[15:8], "R9 read after recovery");
    bus_stop();
    check_cfg("R7 reads left bank intact");

    #100;
    summary();
    $finish;
  end

endmodule